// File: doc/BRIEF.md
# Dual-Port Burst SRAM Core with Double-Rate Data

This block is a synthesizable model of a quad-data-rate static memory with a small internal array. Write data enters on its own input bus and read data leaves on its own output bus, so neither bus ever turns around. One address bus is shared: the read address is taken on the rising clock edge and the write address on the falling edge half a cycle later. Every access moves a burst of two 18-bit words, one per clock phase.

Each port has its own active-low select, so one read and one write can be accepted in every clock cycle. The storage is split into two banks, one per burst beat, and each 18-bit word is split into two 9-bit byte lanes with separate active-low write enables. A single clock drives the block; the rising edge plays the main input and output clock and the falling edge plays the complementary one.

Both ports run at a fixed rate and have no back-pressure: a selected access is always accepted, and read data appears at a fixed latency whether or not anyone is ready for it. There is no ready signal in either direction; `rvalid` marks the two read beats.

Top module: `qdr_sram_core`

## Requirements
- R1: While `rst_n` is low and after its release, before any read, `rvalid` is 0 and `rdata` is 0.
- R2: A read is accepted when `rd_sel_n` is 0 at a rising edge, using `addr` from that same edge. Its first word (bank 0) is driven from the falling edge of the next cycle, its second word (bank 1) from the rising edge after that, and `rvalid` is 1 during exactly those two half-cycles.
- R3: When `rd_sel_n` is 1 at a rising edge, no read beats are produced for that cycle: `rvalid` stays 0 in the two matching half-cycles.
- R4: A write is accepted when `wr_sel_n` is 0 at a rising edge. `wdata` at that rising edge is the first word (bank 0); `addr` and `wdata` at the following falling edge are the write address and the second word (bank 1). Both words are committed at the next rising edge and are returned by a later read of that address.
- R5: When `wr_sel_n` is 1 at a rising edge, `wdata`, `byte_en_n` and the next falling-edge `addr` are ignored and the array is unchanged.
- R6: `byte_en_n` is sampled with each beat of a write; bit 0 low enables data bits 8:0 and bit 1 low enables data bits 17:9 of that beat. Lanes whose bit is 1 keep their previous contents.
- R7: A read and a write accepted in the same cycle to the same address return the newly written data for enabled lanes and the old contents for masked lanes.
- R8: Reads accepted on consecutive cycles produce an unbroken stream of beats with `rvalid` held high.
- R9: A read and a write accepted in the same cycle to different addresses proceed independently; the read returns the address's previous contents and the write is committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock; rising edge and falling edge each sample inputs |
| rst_n | input | 1 | Asynchronous active-low reset of control and output registers |
| addr | input | ADDR_W | Shared address: read address at rising edge, write address at falling edge |
| rd_sel_n | input | 1 | Active-low read select, sampled at the rising edge |
| wr_sel_n | input | 1 | Active-low write select, sampled at the rising edge |
| byte_en_n | input | 2 | Active-low byte-lane write enables, sampled with each write beat |
| wdata | input | 18 | Write data, one word per clock edge |
| rdata | output | 18 | Read data, one word per half-cycle |
| rvalid | output | 1 | High during the two half-cycles that carry read beats |

## Verification
The bench chases the same-cycle read/write collision on one address with mixed lane masks: a design without forwarding would return stale words there, and one that forwards whole words would overwrite masked lanes. It runs reads back to back, where a latency or beat-order slip shows up as swapped words or a gap in `rvalid`. Writes with the select high but live data test that the write path really gates on its select, since a design that commits anyway corrupts a word that is later read. Idle half-cycles are checked too, so a stray `rvalid` from a deselected read fails the run.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  localparam int LANE_W = 9;
  localparam int LANES  = 2;
  localparam int BEATS  = 2;
  localparam int WORD_W = LANE_W * LANES;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_t;
endpackage

// File: rtl/qdr_wr_capture.sv
// Write-side input registers: beat 0 and select on the rising edge,
// address and beat 1 on the falling edge, commit on the next rising edge.
module qdr_wr_capture
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_sel_n,
  input  logic [ADDR_W-1:0]       addr,
  input  word_t                   wdata,
  input  lane_t                   byte_en_n,
  output logic                    commit,
  output logic [ADDR_W-1:0]       commit_addr,
  output word_t [BEATS-1:0]       commit_data,
  output lane_t [BEATS-1:0]       commit_lanes
);
  logic  sel_q;
  word_t d0_q, d1_q;
  lane_t l0_q, l1_q;

  // rising edge: select plus first beat
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      d0_q  <= '0;
      l0_q  <= '0;
    end else begin
      sel_q <= !wr_sel_n;
      d0_q  <= wdata;
      l0_q  <= ~byte_en_n;
    end
  end

  // falling edge: address plus second beat, only for a selected write (R5)
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit      <= 1'b0;
      commit_addr <= '0;
      d1_q        <= '0;
      l1_q        <= '0;
    end else begin
      commit <= sel_q;
      if (sel_q) begin
        commit_addr <= addr;
        d1_q        <= wdata;
        l1_q        <= ~byte_en_n;
      end
    end
  end

  assign commit_data  = {d1_q, d0_q};
  assign commit_lanes = {l1_q, l0_q};
endmodule

// File: rtl/qdr_bank.sv
// One burst-beat bank: a separate array per byte lane so each lane
// has its own write strobe.
module qdr_bank
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  lane_t             lanes,
  input  logic [ADDR_W-1:0] waddr,
  input  word_t             wdata,
  input  logic [ADDR_W-1:0] raddr,
  output word_t             rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && lanes[l])
        mem[waddr] <= wdata[l*LANE_W +: LANE_W];
    end

    assign rdata[l*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/qdr_rd_path.sv
// Read side: address register, fetch with same-cycle write forwarding,
// and the double-rate output registers.
module qdr_rd_path
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_sel_n,
  input  logic [ADDR_W-1:0]   addr,
  output logic [ADDR_W-1:0]   fetch_addr,
  input  word_t [BEATS-1:0]   bank_rdata,
  input  logic                commit,
  input  logic [ADDR_W-1:0]   commit_addr,
  input  word_t [BEATS-1:0]   commit_data,
  input  lane_t [BEATS-1:0]   commit_lanes,
  output word_t               rdata,
  output logic                rvalid
);
  logic              req_q;
  logic [ADDR_W-1:0] ra_q;
  logic              hold_v;
  word_t [BEATS-1:0] hold_q;
  word_t [BEATS-1:0] fetched;
  logic              hit;
  word_t             rise_q, fall_q;
  logic              rise_v, fall_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      ra_q  <= '0;
    end else begin
      req_q <= !rd_sel_n;
      if (!rd_sel_n) ra_q <= addr;
    end
  end

  assign fetch_addr = ra_q;
  assign hit        = commit && (commit_addr == ra_q);

  // R7: a write of the same cycle is merged lane by lane
  always_comb begin
    for (int b = 0; b < BEATS; b++) begin
      for (int l = 0; l < LANES; l++) begin
        fetched[b][l*LANE_W +: LANE_W] = (hit && commit_lanes[b][l])
          ? commit_data[b][l*LANE_W +: LANE_W]
          : bank_rdata[b][l*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_v <= 1'b0;
      hold_q <= '0;
      rise_q <= '0;
      rise_v <= 1'b0;
    end else begin
      hold_v <= req_q;
      if (req_q) hold_q <= fetched;
      rise_q <= hold_q[1];
      rise_v <= hold_v;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_q <= '0;
      fall_v <= 1'b0;
    end else begin
      fall_q <= hold_q[0];
      fall_v <= hold_v;
    end
  end

  // the clock selects which phase register drives the pins
  assign rdata  = clk ? rise_q : fall_q;
  assign rvalid = clk ? rise_v : fall_v;
endmodule

// File: rtl/qdr_sram_core.sv
module qdr_sram_core
  import qdr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_sel_n,
  input  logic              wr_sel_n,
  input  logic [1:0]        byte_en_n,
  input  logic [17:0]       wdata,
  output logic [17:0]       rdata,
  output logic              rvalid
);
  logic              wr_commit;
  logic [ADDR_W-1:0] wr_addr;
  word_t [BEATS-1:0] wr_data;
  lane_t [BEATS-1:0] wr_lanes;
  logic [ADDR_W-1:0] rd_addr;
  word_t [BEATS-1:0] bank_rdata;

  qdr_wr_capture #(.ADDR_W(ADDR_W)) u_wr (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_sel_n     (wr_sel_n),
    .addr         (addr),
    .wdata        (wdata),
    .byte_en_n    (byte_en_n),
    .commit       (wr_commit),
    .commit_addr  (wr_addr),
    .commit_data  (wr_data),
    .commit_lanes (wr_lanes)
  );

  for (genvar b = 0; b < BEATS; b++) begin : g_bank
    qdr_bank #(.ADDR_W(ADDR_W)) u_bank (
      .clk   (clk),
      .we    (wr_commit),
      .lanes (wr_lanes[b]),
      .waddr (wr_addr),
      .wdata (wr_data[b]),
      .raddr (rd_addr),
      .rdata (bank_rdata[b])
    );
  end

  qdr_rd_path #(.ADDR_W(ADDR_W)) u_rd (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_sel_n     (rd_sel_n),
    .addr         (addr),
    .fetch_addr   (rd_addr),
    .bank_rdata   (bank_rdata),
    .commit       (wr_commit),
    .commit_addr  (wr_addr),
    .commit_data  (wr_data),
    .commit_lanes (wr_lanes),
    .rdata        (rdata),
    .rvalid       (rvalid)
  );
endmodule

// File: rtl/qdr_sram_core_chk.sv
module qdr_sram_core_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_sel_n,
  input logic wr_sel_n,
  input logic rvalid,
  input logic commit
);
  // R2
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_sel_n |-> ##2 rvalid);

  // R3
  read_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel_n |-> ##2 !rvalid);

  // R4
  write_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(!wr_sel_n));

  // R5
  write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel_n |=> !commit);
endmodule

bind qdr_sram_core qdr_sram_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_sel_n (rd_sel_n),
  .wr_sel_n (wr_sel_n),
  .rvalid   (rvalid),
  .commit   (wr_commit)
);

// File: tb/qdr_sram_core_test.sv
module qdr_sram_core_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        rd_sel_n = 1'b1;
  logic        wr_sel_n = 1'b1;
  logic [1:0]  byte_en_n = 2'b11;
  logic [17:0] wdata = '0;
  logic [17:0] rdata;
  logic        rvalid;

  qdr_sram_core uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_sel_n(rd_sel_n),
    .wr_sel_n(wr_sel_n), .byte_en_n(byte_en_n), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid)
  );

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    int          due;
    logic [17:0] w0;
    logic [17:0] w1;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [17:0] m0 [16];
  logic [17:0] m1 [16];
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [17:0] merge(logic [17:0] old, logic [17:0] d, logic [1:0] ben);
    logic [17:0] r = old;
    if (!ben[0]) r[8:0]  = d[8:0];
    if (!ben[1]) r[17:9] = d[17:9];
    return r;
  endfunction

  // driver: one clock cycle of stimulus; updates the model and the scoreboard
  task automatic issue(bit rd, int ra, bit wr, int wa, logic [17:0] d0, logic [17:0] d1,
                       logic [1:0] be0, logic [1:0] be1, string tag);
    int n;
    @(negedge clk); #1;
    rd_sel_n  = !rd;
    addr      = 8'(ra);
    wr_sel_n  = !wr;
    wdata     = d0;
    byte_en_n = be0;
    @(posedge clk); #1;
    n         = cyc;
    addr      = 8'(wa);
    wdata     = d1;
    byte_en_n = be1;
    if (wr) begin
      m0[wa] = merge(m0[wa], d0, be0);
      m1[wa] = merge(m1[wa], d1, be1);
    end
    if (rd) sb.push_back('{due: n + 1, w0: m0[ra], w1: m1[ra], tag: tag});
  endtask

  task automatic idle(int k);
    for (int i = 0; i < k; i++) issue(0, 0, 0, 0, 18'h15a5a, 18'h2a5a5, 2'b00, 2'b00, "idle");
  endtask

  // monitor: compares each beat against the scoreboard head
  initial begin
    exp_t        it;
    bit          pend;
    logic [17:0] w1;
    string       tg;
    pend = 0;
    w1 = '0;
    @(posedge rst_n);
    forever begin
      @(negedge clk); #2;
      if (rvalid) begin
        if (sb.size() == 0 || sb[0].due != cyc) begin
          chk(0, "R3 unexpected first beat", rdata, 18'h0);
        end else begin
          it = sb.pop_front();
          chk(rdata === it.w0, {it.tag, " beat0"}, rdata, it.w0);
          pend = 1;
          w1 = it.w1;
          tg = it.tag;
        end
      end else if (sb.size() != 0 && sb[0].due == cyc) begin
        it = sb.pop_front();
        chk(0, {"R2 missing beat0 ", it.tag}, rdata, it.w0);
      end
      @(posedge clk); #2;
      if (pend) begin
        chk(rvalid === 1'b1, {tg, " rvalid beat1"}, 18'(rvalid), 18'h1);
        chk(rdata === w1, {tg, " beat1"}, rdata, w1);
        pend = 0;
      end else begin
        chk(rvalid === 1'b0, "R3 idle rvalid", 18'(rvalid), 18'h0);
      end
    end
  end

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL R2 watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 3);
    // R1: reset state
    chk(rvalid === 1'b0, "R1 rvalid in reset", 18'(rvalid), 18'h0);
    chk(rdata === 18'h0, "R1 rdata in reset", rdata, 18'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    chk(rvalid === 1'b0, "R1 rvalid after reset", 18'(rvalid), 18'h0);
    chk(rdata === 18'h0, "R1 rdata after reset", rdata, 18'h0);

    // R4: fill the low 16 addresses with full writes
    for (int a = 0; a < 16; a++)
      issue(0, 0, 1, a, 18'(a * 18'h111 + 18'h100), 18'(a * 18'h0f0f + 18'h3), 2'b00, 2'b00, "R4");
    // R8: back-to-back read of every word
    for (int a = 0; a < 16; a++) issue(1, a, 0, 0, 18'h0, 18'h0, 2'b11, 2'b11, "R8 R4 stream");
    idle(2);

    // R6: lane-masked writes, each beat with its own mask
    issue(0, 0, 1, 5, 18'h3ffff, 18'h3ffff, 2'b10, 2'b01, "R6");
    issue(0, 0, 1, 6, 18'h00000, 18'h15555, 2'b01, 2'b11, "R6");
    issue(0, 0, 1, 7, 18'h2aaaa, 18'h00000, 2'b11, 2'b10, "R6");
    issue(1, 5, 0, 0, 18'h0, 18'h0, 2'b11, 2'b11, "R6 lanes");
    issue(1, 6, 0, 0, 18'h0, 18'h0, 2'b11, 2'b11, "R6 lanes");
    issue(1, 7, 0, 0, 18'h0, 18'h0, 2'b11, 2'b11, "R6 lanes");
    idle(1);

    // R5: deselected write with live data must not change address 3
    issue(0, 0, 0, 3, 18'h1dead, 18'h2beef, 2'b00, 2'b00, "R5");
    idle(1);
    issue(1, 3, 0, 0, 18'h0, 18'h0, 2'b11, 2'b11, "R5 unchanged");
    idle(2);

    // R7: same-cycle same-address collision, full and partial masks
    issue(1, 9, 1, 9, 18'h12345, 18'h2468a, 2'b00, 2'b00, "R7 full");
    issue(1, 10, 1, 10, 18'h3c3c3, 18'h0f0f0, 2'b10, 2'b01, "R7 masked");
    issue(1, 11, 1, 11, 18'h11111, 18'h22222, 2'b11, 2'b11, "R7 none");
    // R9: same cycle, different addresses
    issue(1, 12, 1, 13, 18'h0abcd, 18'h1bcde, 2'b00, 2'b00, "R9 read");
    issue(1, 13, 0, 0, 18'h0, 18'h0, 2'b11, 2'b11, "R9 written");
    idle(1);

    // R3: gaps between reads
    issue(1, 1, 0, 0, 18'h0, 18'h0, 2'b11, 2'b11, "R3 sparse");
    idle(3);
    issue(1, 2, 0, 0, 18'h0, 18'h0, 2'b11, 2'b11, "R3 sparse");
    idle(1);

    // mixed traffic
    for (int i = 0; i < 400; i++) begin
      int ra = int'($urandom_range(0, 15));
      int wa = int'($urandom_range(0, 15));
      issue(bit'($urandom_range(0, 1)), ra, bit'($urandom_range(0, 1)), wa,
            18'($urandom), 18'($urandom), 2'($urandom), 2'($urandom), "R2 R7 R9 mixed");
    end
    idle(4);
    chk(sb.size() == 0, "R2 scoreboard drained", 18'(sb.size()), 18'h0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule